// File: doc/BRIEF.md
# Multi-Port Vector Register Segment

This block is the storage for one lane slice of a vector unit: 64 words of 32 bits. Seven general read ports and one internal read port return a single word each, combinationally. A wide gather port returns a run of consecutive words as one vector. Six write ports commit at the rising clock edge.

A bulk accumulator path loads the upper group of words in a single cycle. The number of words it writes, and the width of the gather port, follow the vector width parameter, which may be 128, 256 or 512 bits.

The surrounding pipeline is responsible for write-port conflicts and hazards. The block resolves them with a fixed precedence, so its behaviour stays deterministic. Reset leaves the stored words untouched.

Top module: `vreg_segment`

## Requirements
- R1: The array holds 64 words of 32 bits addressed by 6-bit addresses; a read port returns the word at its address in the same cycle, without a clock edge.
- R2: The seven general read ports are independent; each may address any word, including the same word as another port, in the same cycle.
- R3: The internal read port returns the same word as a general read port given the same address.
- R4: A write port changes the array only when its valid bit is high; with every valid low, no word changes.
- R5: Reads during a cycle show the contents before that cycle's writes; written data is readable from the following cycle.
- R6: Six enabled write ports aimed at distinct words all commit in the same cycle.
- R7: When several enabled write ports target one word, the highest-numbered port's data is stored.
- R8: The gather port ignores its four low address bits, so the base is the address rounded down to a multiple of 16. It returns VEC_W/32 words from that base, with the base word in bits [31:0] and each next word in the next 32 bits.
- R9: When acc_valid_i is high, word i of acc_data_i (bits [32i+31:32i]) is written to entry 48+i for every i below VEC_W/32, all in one edge.
- R10: In a cycle with both an accumulator load and port writes, the accumulator data wins on entries 48 to 48+VEC_W/32-1. Port writes to other entries still commit.
- R11: Asserting rst_ni low does not change the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (does not clear storage) |
| rd_addr_i | input | 42 | Seven 6-bit read addresses, port p at [6p+5:6p] |
| rd_data_o | output | 224 | Seven 32-bit read words, port p at [32p+31:32p] |
| int_addr_i | input | 6 | Internal read address |
| int_data_o | output | 32 | Internal read word |
| tp_addr_i | input | 6 | Gather base address (low four bits ignored) |
| tp_data_o | output | VEC_W | Gathered consecutive words |
| wr_valid_i | input | 6 | Per-port write enable |
| wr_addr_i | input | 36 | Six 6-bit write addresses |
| wr_data_i | input | 192 | Six 32-bit write words |
| acc_valid_i | input | 1 | Accumulator bulk load enable |
| acc_data_i | input | VEC_W | Accumulator words, word i at [32i+31:32i] |

## Verification
The array is first filled with a distinct word at every address through all six write ports. Every entry is then read back through rotating ports, which exposes decode errors and ports swapped with one another. A table of single writes on varying ports tells a working port apart from one whose enable or address is miswired, and each of those reads before the edge separates old data from new. Directed cases cover colliding ports, a write with valid low, unaligned gather addresses, an accumulator load overlapping port writes, and a reset pulse. Each one distinguishes the specified precedence or retention from the opposite choice.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_ENTRY  = 64;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned ACC_BASE = 48;
  localparam int unsigned TP_LSB   = 4;   // gather base alignment (16 entries)

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/vrs_wr_merge.sv
module vrs_wr_merge
  import vrs_pkg::*;
#(
  parameter int unsigned NUM_WR = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic [NUM_WR-1:0]            wr_valid_i,
  input  logic [NUM_WR*ADDR_W-1:0]     wr_addr_i,
  input  logic [NUM_WR*WORD_W-1:0]     wr_data_i,
  input  logic                         acc_valid_i,
  input  logic [LANES*WORD_W-1:0]      acc_data_i,
  output logic [N_ENTRY-1:0]           ent_we_o,
  output logic [N_ENTRY-1:0][WORD_W-1:0] ent_wd_o
);
  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    logic  port_we;
    word_t port_wd;

    // ascending scan: the last match (highest port) wins
    always_comb begin
      port_we = 1'b0;
      port_wd = '0;
      for (int w = 0; w < NUM_WR; w++) begin
        if (wr_valid_i[w] && (wr_addr_i[w*ADDR_W +: ADDR_W] == ADDR_W'(e))) begin
          port_we = 1'b1;
          port_wd = wr_data_i[w*WORD_W +: WORD_W];
        end
      end
    end

    if ((e >= ACC_BASE) && (e < ACC_BASE + LANES)) begin : g_acc
      always_comb begin
        ent_we_o[e] = port_we | acc_valid_i;
        ent_wd_o[e] = acc_valid_i ? acc_data_i[(e-ACC_BASE)*WORD_W +: WORD_W] : port_wd;
      end
    end else begin : g_plain
      always_comb begin
        ent_we_o[e] = port_we;
        ent_wd_o[e] = port_wd;
      end
    end
  end
endmodule

// File: rtl/vrs_store.sv
module vrs_store
  import vrs_pkg::*;
(
  input  logic                           clk_i,
  input  logic [N_ENTRY-1:0]             ent_we_i,
  input  logic [N_ENTRY-1:0][WORD_W-1:0] ent_wd_i,
  output logic [N_ENTRY-1:0][WORD_W-1:0] mem_o
);
  // no reset: contents persist across rst_ni
  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (ent_we_i[e]) mem_o[e] <= ent_wd_i[e];
    end
  end
endmodule

// File: rtl/vrs_rd_port.sv
module vrs_rd_port
  import vrs_pkg::*;
(
  input  logic [N_ENTRY-1:0][WORD_W-1:0] mem_i,
  input  addr_t                          addr_i,
  output word_t                          data_o
);
  assign data_o = mem_i[addr_i];
endmodule

// File: rtl/vrs_gather.sv
module vrs_gather
  import vrs_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [N_ENTRY-1:0][WORD_W-1:0] mem_i,
  input  addr_t                          addr_i,
  output logic [LANES*WORD_W-1:0]        data_o
);
  localparam int unsigned BLK_W = ADDR_W - TP_LSB;

  logic [BLK_W-1:0] blk;
  assign blk = addr_i[ADDR_W-1:TP_LSB];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    addr_t idx;
    assign idx = {blk, TP_LSB'(i)};
    assign data_o[i*WORD_W +: WORD_W] = mem_i[idx];
  end
endmodule

// File: rtl/vreg_segment.sv
module vreg_segment
  import vrs_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned NUM_RD = 7,
  parameter int unsigned NUM_WR = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD*WORD_W-1:0]   rd_data_o,
  input  logic [ADDR_W-1:0]          int_addr_i,
  output logic [WORD_W-1:0]          int_data_o,
  input  logic [ADDR_W-1:0]          tp_addr_i,
  output logic [VEC_W-1:0]           tp_data_o,
  input  logic [NUM_WR-1:0]          wr_valid_i,
  input  logic [NUM_WR*ADDR_W-1:0]   wr_addr_i,
  input  logic [NUM_WR*WORD_W-1:0]   wr_data_i,
  input  logic                       acc_valid_i,
  input  logic [VEC_W-1:0]           acc_data_i
);
  localparam int unsigned LANES = VEC_W / WORD_W;
  localparam int unsigned TOP_W = NUM_WR - 1;

  if (!(VEC_W == 128 || VEC_W == 256 || VEC_W == 512)) begin : g_bad_vec
    $error("VEC_W must be 128, 256 or 512");
  end

  logic [N_ENTRY-1:0]             ent_we;
  logic [N_ENTRY-1:0][WORD_W-1:0] ent_wd;
  logic [N_ENTRY-1:0][WORD_W-1:0] mem_q;

  vrs_wr_merge #(.NUM_WR(NUM_WR), .LANES(LANES)) u_merge (
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .acc_valid_i(acc_valid_i),
    .acc_data_i (acc_data_i),
    .ent_we_o   (ent_we),
    .ent_wd_o   (ent_wd)
  );

  vrs_store u_store (
    .clk_i   (clk_i),
    .ent_we_i(ent_we),
    .ent_wd_i(ent_wd),
    .mem_o   (mem_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    vrs_rd_port u_rd (
      .mem_i (mem_q),
      .addr_i(rd_addr_i[p*ADDR_W +: ADDR_W]),
      .data_o(rd_data_o[p*WORD_W +: WORD_W])
    );
  end

  vrs_rd_port u_int_rd (
    .mem_i (mem_q),
    .addr_i(int_addr_i),
    .data_o(int_data_o)
  );

  vrs_gather #(.LANES(LANES)) u_gather (
    .mem_i (mem_q),
    .addr_i(tp_addr_i),
    .data_o(tp_data_o)
  );

  // ---------------- assertions ----------------
  addr_t top_addr;
  logic  top_in_acc;
  assign top_addr   = wr_addr_i[TOP_W*ADDR_W +: ADDR_W];
  assign top_in_acc = (int'(top_addr) >= int'(ACC_BASE)) &&
                      (int'(top_addr) <  int'(ACC_BASE + LANES));

  // R7/R6: highest port always lands unless the accumulator covers its entry
  p_top_port_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i[TOP_W] && !(acc_valid_i && top_in_acc))
    |=> mem_q[$past(top_addr)] == $past(wr_data_i[TOP_W*WORD_W +: WORD_W]));

  // R9/R10: last accumulator lane lands regardless of port writes
  p_acc_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> mem_q[ACC_BASE+LANES-1] == $past(acc_data_i[VEC_W-1 -: WORD_W]));

  // R4: idle cycle leaves the array untouched
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|wr_valid_i) && !acc_valid_i) |=> $stable(mem_q));

  // R8: gather lane 0 agrees with a general read of the aligned base
  p_gather_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[ADDR_W-1:0] == {tp_addr_i[ADDR_W-1:TP_LSB], TP_LSB'(0)})
    |-> tp_data_o[WORD_W-1:0] == rd_data_o[WORD_W-1:0]);

  // R3: internal port agrees with general port 0
  p_int_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_addr_i == rd_addr_i[ADDR_W-1:0]) |-> int_data_o == rd_data_o[WORD_W-1:0]);
endmodule

// File: tb/vreg_segment_bench.sv
`timescale 1ns/1ps
module vreg_segment_bench;
  localparam int VEC_W = 128;
  localparam int LANES = VEC_W / 32;
  localparam int NRD = 7;
  localparam int NWR = 6;

  typedef struct packed {
    logic [2:0]  port;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t [11:0] TBL = '{
    '{3'd0, 6'd0,  32'hDEAD0001}, '{3'd1, 6'd63, 32'h0BAD0002},
    '{3'd2, 6'd17, 32'hFFFFFFFF}, '{3'd3, 6'd48, 32'h00000000},
    '{3'd4, 6'd31, 32'h12345678}, '{3'd5, 6'd32, 32'h87654321},
    '{3'd0, 6'd47, 32'hA5A5A5A5}, '{3'd1, 6'd1,  32'h5A5A5A5A},
    '{3'd2, 6'd62, 32'h80000001}, '{3'd3, 6'd15, 32'h7FFFFFFE},
    '{3'd4, 6'd16, 32'hC0FFEE00}, '{3'd5, 6'd50, 32'h00C0FFEE}};

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NRD*6-1:0]   rd_addr_i = '0;
  logic [NRD*32-1:0]  rd_data_o;
  logic [5:0]         int_addr_i = '0;
  logic [31:0]        int_data_o;
  logic [5:0]         tp_addr_i = '0;
  logic [VEC_W-1:0]   tp_data_o;
  logic [NWR-1:0]     wr_valid_i = '0;
  logic [NWR*6-1:0]   wr_addr_i = '0;
  logic [NWR*32-1:0]  wr_data_i = '0;
  logic               acc_valid_i = 1'b0;
  logic [VEC_W-1:0]   acc_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [64];

  always #4 clk_i = ~clk_i;

  vreg_segment #(.VEC_W(VEC_W)) u_vreg_segment (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, int p, int a);
    rd_addr_i[p*6 +: 6] = 6'(a);
    #1;
    chk(req, rd_data_o[p*32 +: 32], model[a]);
  endtask

  // apply current write inputs at an edge, update model, return at negedge
  task automatic commit();
    for (int w = 0; w < NWR; w++)
      if (wr_valid_i[w]) model[wr_addr_i[w*6 +: 6]] = wr_data_i[w*32 +: 32];
    if (acc_valid_i)
      for (int i = 0; i < LANES; i++) model[48+i] = acc_data_i[i*32 +: 32];
    @(posedge clk_i);
    @(negedge clk_i);
    wr_valid_i = '0;
    acc_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // fill all entries, six per cycle (R6)
    for (int b = 0; b < 64; b += NWR) begin
      for (int w = 0; w < NWR; w++) begin
        wr_valid_i[w] = (b + w) < 64;
        wr_addr_i[w*6 +: 6] = 6'((b + w) % 64);
        wr_data_i[w*32 +: 32] = 32'h3C000000 ^ (32'(b + w) * 32'h01030507);
      end
      commit();
    end

    // R1 R2: every entry through rotating read ports
    for (int e = 0; e < 64; e++) rd_chk($sformatf("R1 R2 entry %0d", e), e % NRD, e);

    // R2: all seven ports on one entry at once
    for (int p = 0; p < NRD; p++) rd_addr_i[p*6 +: 6] = 6'd9;
    #1;
    for (int p = 0; p < NRD; p++) chk("R2 shared address", rd_data_o[p*32 +: 32], model[9]);

    // R3: internal port
    for (int e = 0; e < 64; e += 7) begin
      int_addr_i = 6'(e);
      #1;
      chk("R3 internal read", int_data_o, model[e]);
    end

    // table walk: R4/R5 single writes on each port
    for (int t = 0; t < 12; t++) begin
      logic [31:0] old;
      int p;
      p = int'(TBL[t].port);
      old = model[TBL[t].addr];
      wr_valid_i[p] = 1'b1;
      wr_addr_i[p*6 +: 6] = TBL[t].addr;
      wr_data_i[p*32 +: 32] = TBL[t].data;
      rd_addr_i[(t % NRD)*6 +: 6] = TBL[t].addr;
      #1;
      chk("R5 old value before edge", rd_data_o[(t % NRD)*32 +: 32], old);
      commit();
      rd_chk("R4 R5 table write visible", t % NRD, int'(TBL[t].addr));
    end

    // R7: ports 1 and 4 collide on entry 10, port 4 wins
    wr_valid_i = 6'b010010;
    wr_addr_i[1*6 +: 6] = 6'd10; wr_data_i[1*32 +: 32] = 32'h11111111;
    wr_addr_i[4*6 +: 6] = 6'd10; wr_data_i[4*32 +: 32] = 32'h44444444;
    commit();
    rd_addr_i[0 +: 6] = 6'd10;
    #1;
    chk("R7 higher port wins", rd_data_o[0 +: 32], 32'h44444444);

    // R4: valid low, address and data driven
    wr_addr_i[2*6 +: 6] = 6'd20; wr_data_i[2*32 +: 32] = 32'hBADBAD00;
    @(posedge clk_i); @(negedge clk_i);
    rd_chk("R4 valid low ignored", 2, 20);

    // R8: gather with unaligned addresses
    foreach (TBL[k]) ; // no-op keeps table referenced in loops above
    for (int a = 0; a < 64; a += 13) begin
      tp_addr_i = 6'(a);
      #1;
      for (int i = 0; i < LANES; i++)
        chk($sformatf("R8 gather addr %0d lane %0d", a, i), tp_data_o[i*32 +: 32],
            model[(a & 48) + i]);
    end

    // R9 R10: accumulator load with overlapping and disjoint port writes
    acc_valid_i = 1'b1;
    for (int i = 0; i < LANES; i++) acc_data_i[i*32 +: 32] = 32'hACC00000 + 32'(i);
    wr_valid_i = 6'b100011;
    wr_addr_i[0*6 +: 6] = 6'd49; wr_data_i[0*32 +: 32] = 32'h0000BEEF;
    wr_addr_i[1*6 +: 6] = 6'd20; wr_data_i[1*32 +: 32] = 32'h20202020;
    wr_addr_i[5*6 +: 6] = 6'(48 + LANES); wr_data_i[5*32 +: 32] = 32'h55550000;
    begin
      // model: ports first, accumulator overrides its range
      model[20] = 32'h20202020;
      model[48 + LANES] = 32'h55550000;
      for (int i = 0; i < LANES; i++) model[48+i] = 32'hACC00000 + 32'(i);
      wr_valid_i = 6'b100011;
      @(posedge clk_i); @(negedge clk_i);
      wr_valid_i = '0; acc_valid_i = 1'b0;
    end
    tp_addr_i = 6'd48;
    #1;
    for (int i = 0; i < LANES; i++)
      chk("R9 accumulator lane", tp_data_o[i*32 +: 32], 32'hACC00000 + 32'(i));
    rd_chk("R10 accumulator beats port", 3, 49);
    rd_chk("R10 disjoint port write lands", 4, 20);
    rd_chk("R10 port write above acc range", 5, 48 + LANES);

    // R11: reset pulse keeps contents
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int e = 0; e < 64; e += 5) rd_chk("R11 contents kept over reset", e % NRD, e);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule